// File: doc/BRIEF.md
# Spare Row, Column and Subarray Remapper

This block translates a logical memory address into a physical location inside an array built with more storage than the user sees. The array has a few extra rows in each subarray, one extra data column, and one extra subarray: five are built and four are presented. A small bank of configuration registers plays the role of repair fuses. It is loaded during a test or boot phase while a program-enable input is high, and it is then locked until the next reset.

On every access the block works in the same cycle. It compares the logical row with the programmed list of faulty rows and sends a matching row to the spare row assigned to it. It steers the data bits around one faulty column, on writes and on reads. It skips the subarray that has been mapped out. The logical capacity is fixed. If more faulty rows are reported than spares exist, the block raises a repair-failed flag and does not shrink the memory.

The physical array sits outside the block and is addressed by the subarray, row and column-expanded data outputs.

Top module: `remap_top`

## Requirements
- R1: After reset no entry is valid and the block is unlocked, so the mapping is the identity. The physical row equals the logical row, the physical subarray equals the logical subarray, and `phys_wdata` is `{1'b0, wdata}`. The `spare_hit`, `cfg_err`, `repair_fail` and `locked` outputs are all low.
- R2: A configuration write takes effect at the clock edge where both `cfg_we` and `prog_en` are high. With `prog_en` low it is ignored. Select codes: 0 to NSPARE-1 set a spare entry, with bit 4 as valid and bits 3:0 as the faulty row. NSPARE (2) sets the faulty column, with bit 4 as valid and bits 3:0 as the column. NSPARE+1 (3) sets the mapped-out subarray, with bit 3 as valid and bits 2:0 as the index. NSPARE+2 (4) sets the count of faulty rows found. NSPARE+3 (5) with bit 0 set engages the lock.
- R3: When the logical row matches a valid spare entry k, `phys_row` is ROWS+k (16+k) and `spare_hit` is high, in the same cycle as the address. Otherwise `phys_row` equals the logical row and `spare_hit` is low.
- R4: If two valid spare entries hold the same faulty row, `cfg_err` is high and the lower-indexed spare is used for that row.
- R5: With faulty column c valid, the physical data word is DATA_W+1 bits wide. Bits below c pass straight through, physical bit c is written as 0, and bits above c shift up by one. Reads apply the inverse, so the faulty column never reaches `rdata`.
- R6: With subarray b mapped out, logical subarray s goes to physical s when s < b and to s+1 otherwise. With no valid entry the mapping is the identity.
- R7: `repair_fail` is high exactly when the programmed faulty-row count exceeds NSPARE.
- R8: Writing the lock raises `locked`. From then until reset every configuration write is ignored, even with `prog_en` high.
- R9: With a full repair programmed, every logical address of the fixed capacity maps to a distinct physical location. Data written to each address reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Allows configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 5 | Configuration write value |
| log_sub | input | 2 | Logical subarray |
| log_row | input | 4 | Logical row |
| wdata | input | 8 | Logical write data |
| phys_rdata | input | 9 | Read data from the physical array |
| phys_sub | output | 3 | Physical subarray select |
| phys_row | output | 5 | Physical row select |
| phys_wdata | output | 9 | Column-steered write data |
| rdata | output | 8 | Column-steered read data |
| spare_hit | output | 1 | Access was redirected to a spare row |
| cfg_err | output | 1 | Two valid spare entries name the same row |
| repair_fail | output | 1 | More faulty rows than spare rows |
| locked | output | 1 | Configuration is frozen |

## Verification
The bench aims at the edges of each mapping. These are the rows just before and after a bad row, the last logical subarray sliding into the spare subarray, and the bit positions on either side of the skipped column. A design with an off-by-one in any of these would make two logical addresses share one physical cell, and the full write-then-read sweep exposes that as corrupted data. Duplicate spare entries are programmed deliberately. If the higher-indexed spare won the priority, the design would return the wrong physical row. Writes are also attempted with program-enable low and after locking. A design that leaks either write would redirect a fresh row to a spare.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int ROW_W  = 4;
    localparam int NSPARE = 2;
    localparam int DATA_W = 8;
    localparam int LSUB   = 4;

    localparam int ROWS    = 1 << ROW_W;
    localparam int PROW_W  = $clog2(ROWS + NSPARE);
    localparam int SIDX_W  = (NSPARE > 1) ? $clog2(NSPARE) : 1;
    localparam int PCOL    = DATA_W + 1;
    localparam int COL_W   = $clog2(PCOL);
    localparam int PSUB    = LSUB + 1;
    localparam int LSUB_W  = (LSUB > 1) ? $clog2(LSUB) : 1;
    localparam int PSUB_W  = $clog2(PSUB);
    localparam int SEL_COL  = NSPARE;
    localparam int SEL_SUB  = NSPARE + 1;
    localparam int SEL_CNT  = NSPARE + 2;
    localparam int SEL_LOCK = NSPARE + 3;
    localparam int SEL_W   = $clog2(NSPARE + 4);

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    localparam int CFG_W = max3(ROW_W + 1, COL_W + 1, PSUB_W + 1);

    typedef struct packed {
        logic [NSPARE-1:0]            row_vld;
        logic [NSPARE-1:0][ROW_W-1:0] row_adr;
        logic                         col_vld;
        logic [COL_W-1:0]             col;
        logic                         sub_vld;
        logic [PSUB_W-1:0]            sub;
        logic [ROW_W:0]               bad_cnt;
    } repair_cfg_t;
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output repair_cfg_t       cfg,
    output logic              locked
);
    logic wr_ok;
    assign wr_ok = cfg_we && prog_en && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            locked <= 1'b0;
        end else if (wr_ok) begin
            for (int k = 0; k < NSPARE; k++) begin
                if (cfg_sel == SEL_W'(k)) begin
                    cfg.row_vld[k] <= cfg_wdata[ROW_W];
                    cfg.row_adr[k] <= cfg_wdata[ROW_W-1:0];
                end
            end
            if (cfg_sel == SEL_W'(SEL_COL)) begin
                cfg.col_vld <= cfg_wdata[COL_W];
                cfg.col     <= cfg_wdata[COL_W-1:0];
            end
            if (cfg_sel == SEL_W'(SEL_SUB)) begin
                cfg.sub_vld <= cfg_wdata[PSUB_W];
                cfg.sub     <= cfg_wdata[PSUB_W-1:0];
            end
            if (cfg_sel == SEL_W'(SEL_CNT))
                cfg.bad_cnt <= cfg_wdata[ROW_W:0];
            if (cfg_sel == SEL_W'(SEL_LOCK) && cfg_wdata[0])
                locked <= 1'b1;
        end
    end

    // R8: once locked, stays locked and the settings never move
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);
    p_locked_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(cfg));
    // R2: nothing changes without program enable
    p_no_write_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> ($stable(cfg) && $stable(locked)));
endmodule

// File: rtl/remap_row.sv
module remap_row
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  repair_cfg_t       cfg,
    input  logic [ROW_W-1:0]  log_row,
    output logic [PROW_W-1:0] phys_row,
    output logic              spare_hit,
    output logic              cfg_err,
    output logic              repair_fail
);
    logic [SIDX_W-1:0] hit_idx;

    // scan downwards so the lowest matching index is the one kept
    always_comb begin
        spare_hit = 1'b0;
        hit_idx   = '0;
        for (int k = NSPARE - 1; k >= 0; k--) begin
            if (cfg.row_vld[k] && cfg.row_adr[k] == log_row) begin
                spare_hit = 1'b1;
                hit_idx   = SIDX_W'(k);
            end
        end
    end

    assign phys_row = spare_hit ? (PROW_W'(ROWS) + PROW_W'(hit_idx))
                                : PROW_W'(log_row);

    always_comb begin
        cfg_err = 1'b0;
        for (int i = 0; i < NSPARE; i++)
            for (int j = i + 1; j < NSPARE; j++)
                if (cfg.row_vld[i] && cfg.row_vld[j] &&
                    cfg.row_adr[i] == cfg.row_adr[j])
                    cfg_err = 1'b1;
    end

    assign repair_fail = cfg.bad_cnt > (ROW_W+1)'(NSPARE);

    // R3: a redirected row lands in the spare region, a normal row never does
    p_hit_in_spare_r3: assert property (@(posedge clk) disable iff (rst)
        spare_hit |-> (phys_row >= PROW_W'(ROWS)));
    p_miss_in_main_r3: assert property (@(posedge clk) disable iff (rst)
        !spare_hit |-> (phys_row < PROW_W'(ROWS)));
endmodule

// File: rtl/remap_col.sv
module remap_col
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  repair_cfg_t       cfg,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PCOL-1:0]   phys_rdata,
    output logic [PCOL-1:0]   phys_wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [COL_W-1:0] skip;
    assign skip = (cfg.col_vld && cfg.col <= COL_W'(DATA_W)) ? cfg.col
                                                             : COL_W'(DATA_W);

    for (genvar j = 0; j < PCOL; j++) begin : g_wr
        if (j == 0) begin : g_lo
            assign phys_wdata[0] = (skip == '0) ? 1'b0 : wdata[0];
        end else if (j == DATA_W) begin : g_hi
            assign phys_wdata[j] = (skip == COL_W'(j)) ? 1'b0 : wdata[j-1];
        end else begin : g_mid
            assign phys_wdata[j] = (COL_W'(j) < skip)  ? wdata[j] :
                                   (COL_W'(j) == skip) ? 1'b0     : wdata[j-1];
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_rd
        assign rdata[i] = (COL_W'(i) < skip) ? phys_rdata[i] : phys_rdata[i+1];
    end

    // R5: every logical bit reaches the array, and the skipped column carries none
    p_ones_kept_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(phys_wdata) == $countones(wdata));
    p_skip_zero_r5: assert property (@(posedge clk) disable iff (rst)
        cfg.col_vld |-> (phys_wdata[skip] == 1'b0));
endmodule

// File: rtl/remap_sub.sv
module remap_sub
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  repair_cfg_t       cfg,
    input  logic [LSUB_W-1:0] log_sub,
    output logic [PSUB_W-1:0] phys_sub
);
    logic [PSUB_W-1:0] gone;
    assign gone = (cfg.sub_vld && cfg.sub <= PSUB_W'(LSUB)) ? cfg.sub
                                                            : PSUB_W'(LSUB);

    assign phys_sub = (PSUB_W'(log_sub) < gone) ? PSUB_W'(log_sub)
                                                : PSUB_W'(log_sub) + 1'b1;

    // R6: the mapped-out subarray is never selected and the result stays in range
    p_skip_gone_r6: assert property (@(posedge clk) disable iff (rst)
        cfg.sub_vld |-> (phys_sub != cfg.sub));
    p_sub_range_r6: assert property (@(posedge clk) disable iff (rst)
        phys_sub < PSUB_W'(PSUB));
endmodule

// File: rtl/remap_top.sv
module remap_top
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [LSUB_W-1:0] log_sub,
    input  logic [ROW_W-1:0]  log_row,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PCOL-1:0]   phys_rdata,
    output logic [PSUB_W-1:0] phys_sub,
    output logic [PROW_W-1:0] phys_row,
    output logic [PCOL-1:0]   phys_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              spare_hit,
    output logic              cfg_err,
    output logic              repair_fail,
    output logic              locked
);
    repair_cfg_t cfg;

    remap_cfg u_cfg (
        .clk(clk), .rst(rst), .prog_en(prog_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg(cfg), .locked(locked)
    );

    remap_row u_row (
        .clk(clk), .rst(rst), .cfg(cfg), .log_row(log_row),
        .phys_row(phys_row), .spare_hit(spare_hit),
        .cfg_err(cfg_err), .repair_fail(repair_fail)
    );

    remap_col u_col (
        .clk(clk), .rst(rst), .cfg(cfg), .wdata(wdata),
        .phys_rdata(phys_rdata), .phys_wdata(phys_wdata), .rdata(rdata)
    );

    remap_sub u_sub (
        .clk(clk), .rst(rst), .cfg(cfg), .log_sub(log_sub), .phys_sub(phys_sub)
    );

    // R7: the flag follows the reported count against the spare supply
    p_fail_needs_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(repair_fail) |-> $past(cfg_we && prog_en));
endmodule

// File: tb/test_remap_top.sv
`timescale 1ns/1ps
module test_remap_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [4:0] cfg_wdata = '0;
    logic [1:0] log_sub = '0;
    logic [3:0] log_row = '0;
    logic [7:0] wdata = '0;
    logic [8:0] phys_rdata;
    logic [2:0] phys_sub;
    logic [4:0] phys_row;
    logic [8:0] phys_wdata;
    logic [7:0] rdata;
    logic       spare_hit, cfg_err, repair_fail, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [8:0] mem [5][18];

    always #2.5 clk = ~clk;

    assign phys_rdata = (phys_sub < 3'd5 && phys_row < 5'd18) ? mem[phys_sub][phys_row] : 9'h0;

    remap_top i_remap_top (
        .clk(clk), .rst(rst), .prog_en(prog_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .log_sub(log_sub),
        .log_row(log_row), .wdata(wdata), .phys_rdata(phys_rdata),
        .phys_sub(phys_sub), .phys_row(phys_row), .phys_wdata(phys_wdata),
        .rdata(rdata), .spare_hit(spare_hit), .cfg_err(cfg_err),
        .repair_fail(repair_fail), .locked(locked)
    );

    // {log_sub, log_row, phys_sub, phys_row, spare_hit} with spares at rows 3 and 9,
    // column 2 skipped and subarray 1 mapped out
    localparam logic [14:0] VEC [8] = '{
        {2'd0, 4'd3,  3'd0, 5'd16, 1'b1},
        {2'd0, 4'd9,  3'd0, 5'd17, 1'b1},
        {2'd1, 4'd3,  3'd2, 5'd16, 1'b1},
        {2'd1, 4'd4,  3'd2, 5'd4,  1'b0},
        {2'd2, 4'd0,  3'd3, 5'd0,  1'b0},
        {2'd3, 4'd15, 3'd4, 5'd15, 1'b0},
        {2'd3, 4'd9,  3'd4, 5'd17, 1'b1},
        {2'd2, 4'd8,  3'd3, 5'd8,  1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] sel, logic [4:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_addr(logic [1:0] s, logic [3:0] r);
        log_sub = s; log_row = r;
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < 5; s++)
            for (int r = 0; r < 18; r++)
                mem[s][r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: identity mapping, flags low
        wdata = 8'hA5;
        set_addr(2'd2, 4'd7);
        check("R1 phys_row", 32'(phys_row), 32'd7);
        check("R1 phys_sub", 32'(phys_sub), 32'd2);
        check("R1 phys_wdata", 32'(phys_wdata), 32'h0A5);
        check("R1 flags", {28'd0, spare_hit, cfg_err, repair_fail, locked}, 32'd0);

        // R2: write with prog_en low is ignored
        cfg_write(3'd0, 5'h13);
        set_addr(2'd0, 4'd3);
        check("R2 no hit", 32'(spare_hit), 32'd0);
        check("R2 row kept", 32'(phys_row), 32'd3);

        // program the full repair
        prog_en = 1'b1;
        cfg_write(3'd0, 5'h13);
        cfg_write(3'd1, 5'h19);
        cfg_write(3'd2, 5'h12);
        cfg_write(3'd3, 5'h09);
        cfg_write(3'd4, 5'd2);

        // R3 and R6 from the vector table
        for (int v = 0; v < 8; v++) begin
            set_addr(VEC[v][14:13], VEC[v][12:9]);
            check("R6 phys_sub", 32'(phys_sub), 32'(VEC[v][8:6]));
            check("R3 phys_row", 32'(phys_row), 32'(VEC[v][5:1]));
            check("R3 spare_hit", 32'(spare_hit), 32'(VEC[v][0]));
        end
        check("R7 count at limit", 32'(repair_fail), 32'd0);

        // R5: column 2 skipped
        wdata = 8'hFF; #1;
        check("R5 all ones", 32'(phys_wdata), 32'h1FB);
        wdata = 8'h04; #1;
        check("R5 bit above skip", 32'(phys_wdata), 32'h008);
        wdata = 8'h02; #1;
        check("R5 bit below skip", 32'(phys_wdata), 32'h002);

        // R9: full sweep write then read
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 16; r++) begin
                wdata = {s[1:0], r[3:0], 2'b10};
                set_addr(s[1:0], r[3:0]);
                mem[phys_sub][phys_row] = phys_wdata;
            end
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 16; r++) begin
                set_addr(s[1:0], r[3:0]);
                check("R9 readback", 32'(rdata), 32'({s[1:0], r[3:0], 2'b10}));
            end

        // R7: too many faulty rows reported
        cfg_write(3'd4, 5'd3);
        check("R7 fail high", 32'(repair_fail), 32'd1);
        cfg_write(3'd4, 5'd2);
        check("R7 fail low", 32'(repair_fail), 32'd0);

        // R4: duplicate entries, lower index wins
        cfg_write(3'd1, 5'h13);
        set_addr(2'd0, 4'd3);
        check("R4 cfg_err", 32'(cfg_err), 32'd1);
        check("R4 lower spare", 32'(phys_row), 32'd16);
        cfg_write(3'd1, 5'h19);
        check("R4 err cleared", 32'(cfg_err), 32'd0);

        // R8: lock then attempt rewrite
        cfg_write(3'd5, 5'h01);
        check("R8 locked", 32'(locked), 32'd1);
        cfg_write(3'd0, 5'h15);
        set_addr(2'd0, 4'd5);
        check("R8 row5 untouched", 32'(phys_row), 32'd5);
        set_addr(2'd0, 4'd3);
        check("R8 row3 kept", 32'(phys_row), 32'd16);

        // R1: reset clears everything
        prog_en = 1'b0;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        set_addr(2'd3, 4'd3);
        check("R1 unlocked", 32'(locked), 32'd0);
        check("R1 row identity", 32'(phys_row), 32'd3);
        check("R1 sub identity", 32'(phys_sub), 32'd3);

        finish_run();
    end
endmodule